// File: doc/BRIEF.md
# Converter Operating Mode Sequencer

This block is the supervisory state machine of a high-current DC current converter. It moves the converter through five operating modes: Off, Standby (ready to start), Energized (ready to run), Run and Fault. It does this in response to commands from an upper controller, level fault inputs, and two power-good inputs. Each mode sets a fixed pattern on five power-stage controls: main contactor, precharge contactor, PWM enable, auxiliary power enable and bypass switch. The power stage may switch only in Run. In every other powered mode the switching stage stays off, so the winding current can freewheel through the diode.

The upper controller sends one command per cycle on a valid-qualified 3-bit code. It can read back a 3-bit mode code, a one-hot cause of the fault that caused the shutdown, and a sticky bit that records a rejected command. Once the contactors have been told to close, a programmable settle count must run out before a Run command is honoured. Loss of control power overrides everything else and drops the block to Off with all outputs released.

Top module: `conv_mode_seq`

## Requirements
- R1: While `rst_n` is low, the block is in Off (mode code 0). All five drive outputs are low, `fault_cause` is zero and `illegal_cmd` is low.
- R2: Off moves to Standby only in a cycle where `ctrl_pwr_ok`, `cont_pwr_ok` and `selftest_done` are all high. Otherwise it stays in Off, and commands received in Off have no effect and set no flag.
- R3: A Start command (code 1) in Standby moves the block to Energized. In Energized, the main and precharge contactors are closed and PWM is off.
- R4: A Shutdown command (code 2) in Energized returns the block to Standby with both contactors open.
- R5: A Run command (code 3) in Energized, once the contactors have settled, enters Run. PWM is enabled in Run and in no other mode.
- R6: A Stop command (code 4) in Run returns the block to Energized with PWM off and both contactors still closed.
- R7: A Start is accepted at clock edge c0 with `settle_cycles` = N captured at that edge. A Run command sampled at edge c is accepted only if c − c0 ≥ N+1. An earlier Run is rejected and sets `illegal_cmd`. The settled condition persists through Run→Energized and is lost when the block leaves Energized/Run.
- R8: In Standby, Energized or Run, any high bit of `fault_in` moves the block to Fault on the next edge. This takes priority over any command in the same cycle, and that command is dropped without setting `illegal_cmd`. In Fault, both contactors are open, PWM is off, the bypass switch is closed and auxiliary power stays on.
- R9: On entry to Fault, `fault_cause` latches a one-hot copy of the lowest-numbered active fault bit. It holds while the block stays in Fault, even if other fault bits rise.
- R10: A Reset command (code 5) in Fault with `fault_in` all zero returns the block to Standby and clears `fault_cause` and `illegal_cmd`. A Reset while any fault bit is high has no effect.
- R11: When `ctrl_pwr_ok` is low, the next edge puts the block in Off from any mode. All drive outputs, `fault_cause` and `illegal_cmd` are cleared.
- R12: A command whose code is not valid in the current powered mode leaves the mode unchanged and sets the sticky `illegal_cmd` bit. Codes 0, 6 and 7 are never valid.
- R13: Mode codes are Off=0, Standby=1, Energized=2, Run=3, Fault=4. Auxiliary power is on in every mode except Off. The bypass switch is closed only in Fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_pwr_ok | input | 1 | Control power present |
| cont_pwr_ok | input | 1 | Contactor supply present |
| selftest_done | input | 1 | Sensor and link self-check passed |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (1 Start, 2 Shutdown, 3 Run, 4 Stop, 5 Reset) |
| fault_in | input | NFLT | Level fault requests needing shutdown |
| settle_cycles | input | CNT_W | Contactor settle count, captured on Start |
| main_close | output | 1 | Close main contactor |
| prechg_close | output | 1 | Close precharge contactor |
| pwm_en | output | 1 | Enable converter switching |
| aux_en | output | 1 | Auxiliary power enable |
| bypass_close | output | 1 | Close bypass switch |
| mode_code | output | 3 | Current mode |
| fault_cause | output | NFLT | Latched one-hot fault cause |
| illegal_cmd | output | 1 | Sticky rejected-command flag |

## Verification
The collision that matters is a fault request and a command arriving in the same cycle. The bench provokes it by raising a fault bit in Run together with a Stop strobe, and by sending Reset while a fault bit is still high. The result is judged by the next-cycle mode, the latched cause and the sticky flag: the fault must win, the command must vanish without being flagged, and the Reset must do nothing. A second collision, power loss together with a command, is judged by Off and cleared status on the following edge. A behavioural reference model, compared every cycle, judges all other traffic.

// File: rtl/conv_mode_pkg.sv
package conv_mode_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [2:0] {
    MODE_OFF       = 3'd0,
    MODE_STANDBY   = 3'd1,
    MODE_ENERGIZED = 3'd2,
    MODE_RUN       = 3'd3,
    MODE_FAULT     = 3'd4
  } mode_e;

  localparam logic [CODE_W-1:0] CMD_START    = 3'd1;
  localparam logic [CODE_W-1:0] CMD_SHUTDOWN = 3'd2;
  localparam logic [CODE_W-1:0] CMD_RUN      = 3'd3;
  localparam logic [CODE_W-1:0] CMD_STOP     = 3'd4;
  localparam logic [CODE_W-1:0] CMD_RESET    = 3'd5;

  typedef struct packed {
    logic start;
    logic shutdown;
    logic run;
    logic stop;
    logic reset;
    logic undef;
  } cmd_s;

  typedef struct packed {
    logic main_close;
    logic prechg_close;
    logic pwm_en;
    logic aux_en;
    logic bypass_close;
  } drive_s;

  function automatic drive_s mode_drive(mode_e m);
    drive_s d;
    d = '0;
    unique case (m)
      MODE_OFF:       d = '0;
      MODE_STANDBY:   d.aux_en = 1'b1;
      MODE_ENERGIZED: begin
        d.main_close   = 1'b1;
        d.prechg_close = 1'b1;
        d.aux_en       = 1'b1;
      end
      MODE_RUN: begin
        d.main_close   = 1'b1;
        d.prechg_close = 1'b1;
        d.pwm_en       = 1'b1;
        d.aux_en       = 1'b1;
      end
      MODE_FAULT: begin
        d.aux_en       = 1'b1;
        d.bypass_close = 1'b1;
      end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cms_cmd_decode.sv
module cms_cmd_decode
  import conv_mode_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  output cmd_s              cmd,
  output logic              cmd_any
);

  always_comb begin
    cmd = '0;
    if (cmd_valid) begin
      unique case (cmd_code)
        CMD_START:    cmd.start    = 1'b1;
        CMD_SHUTDOWN: cmd.shutdown = 1'b1;
        CMD_RUN:      cmd.run      = 1'b1;
        CMD_STOP:     cmd.stop     = 1'b1;
        CMD_RESET:    cmd.reset    = 1'b1;
        default:      cmd.undef    = 1'b1;
      endcase
    end
  end

  assign cmd_any = cmd_valid;

endmodule

// File: rtl/cms_settle_timer.sv
module cms_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             hold,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             settled
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (load) begin
      cnt_d   = settle_cycles;
      armed_d = 1'b1;
    end else if (!hold) begin
      armed_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign settled = armed_q && (cnt_q == '0);

endmodule

// File: rtl/cms_fault_latch.sv
module cms_fault_latch #(
  parameter int NFLT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            clear,
  input  logic [NFLT-1:0] fault_in,
  output logic            any_fault,
  output logic [NFLT-1:0] cause
);

  logic [NFLT:0]   seen;
  logic [NFLT-1:0] pick;
  logic [NFLT-1:0] cause_q, cause_d;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NFLT; i++) begin : g_pick
    assign pick[i]   = fault_in[i] & ~seen[i];
    assign seen[i+1] = seen[i] | fault_in[i];
  end

  assign any_fault = seen[NFLT];

  always_comb begin
    cause_d = cause_q;
    if (clear)        cause_d = '0;
    else if (capture) cause_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause = cause_q;

endmodule

// File: rtl/cms_mode_fsm.sv
module cms_mode_fsm
  import conv_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_pwr_ok,
  input  logic  cont_pwr_ok,
  input  logic  selftest_done,
  input  logic  any_fault,
  input  cmd_s  cmd,
  input  logic  cmd_any,
  input  logic  settled,
  output mode_e mode,
  output logic  start_acc,
  output logic  reset_acc,
  output logic  fault_entry,
  output logic  contacts_held,
  output logic  illegal
);

  mode_e mode_q, mode_d;
  logic  ill_q, ill_d;

  always_comb begin
    mode_d      = mode_q;
    ill_d       = ill_q;
    start_acc   = 1'b0;
    reset_acc   = 1'b0;
    fault_entry = 1'b0;
    if (!ctrl_pwr_ok) begin
      mode_d = MODE_OFF;
      ill_d  = 1'b0;
    end else begin
      unique case (mode_q)
        MODE_OFF: begin
          ill_d = 1'b0;
          if (cont_pwr_ok && selftest_done) mode_d = MODE_STANDBY;
        end
        MODE_FAULT: begin
          if (cmd.reset) begin
            if (!any_fault) begin
              mode_d    = MODE_STANDBY;
              reset_acc = 1'b1;
              ill_d     = 1'b0;
            end
          end else if (cmd_any) begin
            ill_d = 1'b1;
          end
        end
        MODE_STANDBY, MODE_ENERGIZED, MODE_RUN: begin
          if (any_fault) begin
            mode_d      = MODE_FAULT;
            fault_entry = 1'b1;
          end else begin
            unique case (mode_q)
              MODE_STANDBY: begin
                if (cmd.start) begin
                  mode_d    = MODE_ENERGIZED;
                  start_acc = 1'b1;
                end else if (cmd_any) begin
                  ill_d = 1'b1;
                end
              end
              MODE_ENERGIZED: begin
                if (cmd.shutdown)            mode_d = MODE_STANDBY;
                else if (cmd.run && settled) mode_d = MODE_RUN;
                else if (cmd_any)            ill_d  = 1'b1;
              end
              MODE_RUN: begin
                if (cmd.stop)     mode_d = MODE_ENERGIZED;
                else if (cmd_any) ill_d  = 1'b1;
              end
              default: mode_d = mode_q;
            endcase
          end
        end
        default: mode_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      ill_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ill_q  <= ill_d;
    end
  end

  assign mode          = mode_q;
  assign illegal       = ill_q;
  assign contacts_held = (mode_q == MODE_ENERGIZED) || (mode_q == MODE_RUN);

endmodule

// File: rtl/conv_mode_seq.sv
module conv_mode_seq
  import conv_mode_pkg::*;
#(
  parameter int NFLT  = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_pwr_ok,
  input  logic             cont_pwr_ok,
  input  logic             selftest_done,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic [NFLT-1:0]  fault_in,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             main_close,
  output logic             prechg_close,
  output logic             pwm_en,
  output logic             aux_en,
  output logic             bypass_close,
  output logic [2:0]       mode_code,
  output logic [NFLT-1:0]  fault_cause,
  output logic             illegal_cmd
);

  cmd_s   cmd;
  logic   cmd_any;
  logic   settled;
  logic   any_fault;
  logic   start_acc, reset_acc, fault_entry, contacts_held;
  mode_e  mode;
  drive_s drv;

  cms_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd       (cmd),
    .cmd_any   (cmd_any)
  );

  cms_settle_timer #(.CNT_W(CNT_W)) u_settle (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (start_acc),
    .hold          (contacts_held),
    .settle_cycles (settle_cycles),
    .settled       (settled)
  );

  cms_fault_latch #(.NFLT(NFLT)) u_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (fault_entry),
    .clear     (reset_acc | ~ctrl_pwr_ok),
    .fault_in  (fault_in),
    .any_fault (any_fault),
    .cause     (fault_cause)
  );

  cms_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_pwr_ok   (ctrl_pwr_ok),
    .cont_pwr_ok   (cont_pwr_ok),
    .selftest_done (selftest_done),
    .any_fault     (any_fault),
    .cmd           (cmd),
    .cmd_any       (cmd_any),
    .settled       (settled),
    .mode          (mode),
    .start_acc     (start_acc),
    .reset_acc     (reset_acc),
    .fault_entry   (fault_entry),
    .contacts_held (contacts_held),
    .illegal       (illegal_cmd)
  );

  assign drv          = mode_drive(mode);
  assign main_close   = drv.main_close;
  assign prechg_close = drv.prechg_close;
  assign pwm_en       = drv.pwm_en;
  assign aux_en       = drv.aux_en;
  assign bypass_close = drv.bypass_close;
  assign mode_code    = mode;

endmodule

// File: rtl/cms_checker.sv
module cms_checker #(
  parameter int NFLT  = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_pwr_ok,
  input logic             cmd_valid,
  input logic [2:0]       cmd_code,
  input logic [NFLT-1:0]  fault_in,
  input logic [CNT_W-1:0] settle_cycles,
  input logic             main_close,
  input logic             prechg_close,
  input logic             pwm_en,
  input logic             aux_en,
  input logic             bypass_close,
  input logic [2:0]       mode_code,
  input logic [NFLT-1:0]  fault_cause,
  input logic             illegal_cmd
);

  a_r5_pwm_only_run: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en |-> (mode_code == 3'd3));

  a_r5_run_from_energized: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd3 && $past(mode_code) != 3'd3) |-> ($past(mode_code) == 3'd2));

  a_r8_fault_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_pwr_ok && (fault_in != '0) && mode_code != 3'd0) |=> (mode_code == 3'd4));

  a_r8_fault_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd4) |-> (bypass_close && aux_en && !main_close && !prechg_close && !pwm_en));

  a_r9_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_cause));

  a_r9_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd4 && ctrl_pwr_ok && !(cmd_valid && cmd_code == 3'd5)) |=> $stable(fault_cause));

  a_r11_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_pwr_ok |=> (mode_code == 3'd0 && !aux_en && fault_cause == '0 && !illegal_cmd));

  a_r12_flag_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(illegal_cmd) |-> $past(cmd_valid));

  a_r13_bypass_only_fault: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_close |-> (mode_code == 3'd4));

endmodule

bind conv_mode_seq cms_checker #(.NFLT(NFLT), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctrl_pwr_ok   (ctrl_pwr_ok),
  .cmd_valid     (cmd_valid),
  .cmd_code      (cmd_code),
  .fault_in      (fault_in),
  .settle_cycles (settle_cycles),
  .main_close    (main_close),
  .prechg_close  (prechg_close),
  .pwm_en        (pwm_en),
  .aux_en        (aux_en),
  .bypass_close  (bypass_close),
  .mode_code     (mode_code),
  .fault_cause   (fault_cause),
  .illegal_cmd   (illegal_cmd)
);

// File: tb/tb_conv_mode_seq.sv
`timescale 1ns/1ps
module tb_conv_mode_seq;

  localparam int NFLT  = 4;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ctrl_pwr_ok, cont_pwr_ok, selftest_done;
  logic             cmd_valid;
  logic [2:0]       cmd_code;
  logic [NFLT-1:0]  fault_in;
  logic [CNT_W-1:0] settle_cycles;
  logic             main_close, prechg_close, pwm_en, aux_en, bypass_close;
  logic [2:0]       mode_code;
  logic [NFLT-1:0]  fault_cause;
  logic             illegal_cmd;

  always #2 clk = ~clk;

  conv_mode_seq #(.NFLT(NFLT), .CNT_W(CNT_W)) dut (.*);

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int              m_mode = 0;
  logic [NFLT-1:0] m_cause = '0;
  bit              m_ill = 1'b0;
  longint          cyc = 0;
  longint          start_cyc = 0;
  longint          m_settle = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cause = '0; m_ill = 0;
    end else begin
      cyc++;
      if (!ctrl_pwr_ok) begin
        m_mode = 0; m_cause = '0; m_ill = 0;
      end else if (m_mode == 0) begin
        if (cont_pwr_ok && selftest_done) m_mode = 1;
      end else if (m_mode == 4) begin
        if (cmd_valid && cmd_code == 3'd5) begin
          if (fault_in == '0) begin m_mode = 1; m_cause = '0; m_ill = 0; end
        end else if (cmd_valid) m_ill = 1;
      end else if (fault_in != '0) begin
        m_mode = 4;
        for (int i = 0; i < NFLT; i++) begin
          if (fault_in[i]) begin m_cause = '0; m_cause[i] = 1'b1; break; end
        end
      end else if (cmd_valid) begin
        if (m_mode == 1 && cmd_code == 3'd1) begin
          m_mode = 2; start_cyc = cyc; m_settle = longint'(settle_cycles);
        end else if (m_mode == 2 && cmd_code == 3'd2) m_mode = 1;
        else if (m_mode == 2 && cmd_code == 3'd3 && (cyc - start_cyc) >= m_settle + 1) m_mode = 3;
        else if (m_mode == 3 && cmd_code == 3'd4) m_mode = 2;
        else m_ill = 1;
      end
    end
  end

  function automatic logic [15:0] pack_exp();
    logic mc, pc, pw, ax, bp;
    mc = (m_mode == 2 || m_mode == 3);
    pc = mc;
    pw = (m_mode == 3);
    ax = (m_mode != 0);
    bp = (m_mode == 4);
    return {4'b0, mc, pc, pw, ax, bp, 3'(m_mode), m_cause};
  endfunction

  function automatic logic [15:0] pack_act();
    return {4'b0, main_close, prechg_close, pwm_en, aux_en, bypass_close, mode_code, fault_cause};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, {16'b0, pack_act()}, {16'b0, pack_exp()}, "outputs vs model");
      chk(cur_req, {31'b0, illegal_cmd}, {31'b0, m_ill}, "illegal flag vs model");
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cmd(logic [2:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    tick();
    cmd_valid = 1'b0; cmd_code = 3'd0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; ctrl_pwr_ok = 0; cont_pwr_ok = 0; selftest_done = 0;
    cmd_valid = 0; cmd_code = 0; fault_in = '0; settle_cycles = 16'd3;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", {16'b0, pack_act(), 15'b0, illegal_cmd}, 32'd0, "reset outputs");
    rst_n = 1'b1;
    tick();

    // R2 Off exit needs all three conditions
    cur_req = "R2";
    ctrl_pwr_ok = 1; cont_pwr_ok = 1; selftest_done = 0;
    cmd(3'd1);
    tick();
    chk("R2", {29'b0, mode_code}, 32'd0, "stays Off without self-check, cmd ignored");
    chk("R2", {31'b0, illegal_cmd}, 32'd0, "no flag in Off");
    selftest_done = 1;
    tick();
    chk("R13", {29'b0, mode_code}, 32'd1, "Standby code");
    chk("R13", {31'b0, aux_en}, 32'd1, "aux on in Standby");

    // R12 illegal commands
    cur_req = "R12";
    cmd(3'd3);
    chk("R12", {29'b0, mode_code}, 32'd1, "Run in Standby ignored");
    chk("R12", {31'b0, illegal_cmd}, 32'd1, "sticky flag set");
    cmd(3'd6);
    chk("R12", {29'b0, mode_code}, 32'd1, "undefined code ignored");

    // R11 power loss clears status
    cur_req = "R11";
    ctrl_pwr_ok = 0;
    tick();
    chk("R11", {29'b0, mode_code, 3'b0, aux_en}, 32'h0, "Off after power loss");
    chk("R11", {31'b0, illegal_cmd}, 32'd0, "flag cleared");
    ctrl_pwr_ok = 1;
    tick();

    // R3 start, R7 settle window
    cur_req = "R3";
    cmd(3'd1);
    chk("R3", {29'b0, mode_code}, 32'd2, "Energized");
    chk("R3", {30'b0, main_close, prechg_close}, 32'd3, "contactors closed");
    cur_req = "R7";
    cmd(3'd3);
    chk("R7", {29'b0, mode_code}, 32'd2, "early Run rejected (c-c0=1)");
    chk("R7", {31'b0, illegal_cmd}, 32'd1, "early Run flagged");
    tick();
    cmd(3'd3);
    chk("R7", {29'b0, mode_code}, 32'd2, "Run at c-c0=3 rejected");
    cur_req = "R5";
    cmd(3'd3);
    chk("R5", {29'b0, mode_code}, 32'd3, "Run at c-c0=4 accepted");
    chk("R5", {31'b0, pwm_en}, 32'd1, "pwm on in Run");

    // R6 stop, re-run without waiting
    cur_req = "R6";
    cmd(3'd4);
    chk("R6", {29'b0, mode_code}, 32'd2, "back to Energized");
    chk("R6", {30'b0, pwm_en, main_close}, 32'd1, "pwm off, main held");
    cmd(3'd3);
    chk("R7", {29'b0, mode_code}, 32'd3, "settled kept after Stop");
    cmd(3'd4);
    cur_req = "R4";
    cmd(3'd2);
    chk("R4", {29'b0, mode_code}, 32'd1, "Shutdown to Standby");
    chk("R4", {30'b0, main_close, prechg_close}, 32'd0, "contactors open");

    // clear flag via power cycle
    ctrl_pwr_ok = 0; tick(); ctrl_pwr_ok = 1; tick();

    // R8 fault beats simultaneous command
    cur_req = "R8";
    settle_cycles = 16'd0;
    cmd(3'd1);
    cmd(3'd3);
    chk("R7", {29'b0, mode_code}, 32'd3, "zero settle: Run next cycle");
    fault_in = 4'b0100;
    cmd(3'd4);
    chk("R8", {29'b0, mode_code}, 32'd4, "fault wins over Stop");
    chk("R8", {27'b0, main_close, prechg_close, pwm_en, aux_en, bypass_close}, 32'h3, "fault drive pattern");
    chk("R8", {31'b0, illegal_cmd}, 32'd0, "dropped cmd not flagged");
    chk("R9", {28'b0, fault_cause}, 32'h4, "cause latched");
    cur_req = "R9";
    fault_in = 4'b0101;
    tick();
    chk("R9", {28'b0, fault_cause}, 32'h4, "cause held on later fault");
    cur_req = "R10";
    cmd(3'd5);
    chk("R10", {29'b0, mode_code}, 32'd4, "Reset ignored while fault active");
    fault_in = '0;
    tick();
    cmd(3'd4);
    chk("R12", {31'b0, illegal_cmd}, 32'd1, "Stop in Fault flagged");
    cmd(3'd5);
    chk("R10", {29'b0, mode_code}, 32'd1, "Reset to Standby");
    chk("R10", {27'b0, fault_cause, illegal_cmd}, 32'd0, "status cleared");

    // R9 simultaneous faults from Standby
    cur_req = "R9";
    fault_in = 4'b1010;
    tick();
    chk("R9", {28'b0, fault_cause}, 32'h2, "lowest index wins");
    fault_in = '0;
    cmd(3'd5);

    // R8 from Energized
    cur_req = "R8";
    cmd(3'd1);
    fault_in = 4'b0001;
    tick();
    chk("R8", {29'b0, mode_code}, 32'd4, "fault from Energized");
    fault_in = '0;
    cmd(3'd5);

    // R11 power loss from Run, R2 contactor supply needed
    cur_req = "R11";
    cmd(3'd1);
    cmd(3'd3);
    ctrl_pwr_ok = 0; cont_pwr_ok = 0;
    cmd(3'd4);
    chk("R11", {27'b0, main_close, prechg_close, pwm_en, aux_en, bypass_close}, 32'd0, "all drive low");
    chk("R11", {29'b0, mode_code}, 32'd0, "Off from Run");
    cur_req = "R2";
    ctrl_pwr_ok = 1;
    tick(); tick();
    chk("R2", {29'b0, mode_code}, 32'd0, "stays Off without contactor supply");
    cont_pwr_ok = 1;
    tick();
    chk("R2", {29'b0, mode_code}, 32'd1, "Standby once all present");
    tick();
    finish_run();
  end

endmodule